// File: doc/BRIEF.md
# Framed serial port with cascade

This block is the converter-side end of a synchronous serial link to a signal processor. It makes the serial clock itself by dividing its own clock. It sends 16-bit words most significant bit first, each one announced by a one-bit-time output sync pulse. It receives 16-bit words announced by an input sync pulse. Transmit words come in through a valid/ready holding register. Received words leave as a parallel word with a one-cycle strobe.

Words can be sent one at a time or streamed back to back. When streaming, the sync for the next word is raised during the last bit of the current word, so no idle bit falls between words. Up to eight ports may share one link as a daisy chain, and no select wires are needed. Each port compares a 3-bit address field inside every received word with its strapped identity. It keeps a word that matches. It sends any other word on down the chain in its next output frame. The input sync may be wired to the output sync, so that input and output words begin on the same serial clock edge.

Top module: `fsp_port`

## Requirements
- R1: Words are 16 bits, sent and received most significant bit first. `ser_dout_o` and `ser_dsync_o` change only in the cycle in which `ser_clk_o` rises. `ser_din_i` and `ser_din_sync_i` are sampled in the cycle in which `ser_clk_o` falls.
- R2: `ser_clk_o` is high for 2^`div_sel_i` cycles of `clk_i` and low for the same number of cycles. `div_sel_i` takes the values 0 to 3, so the bit rate is the port clock divided by 2, 4, 8 or 16.
- R3: `ser_dsync_o` is high for exactly one serial clock period, the period just before the first data bit of a word.
- R4: When a further word is ready by the time the last bit of a word is driven, `ser_dsync_o` is raised alongside that last bit, and the next word's first bit follows in the very next bit period.
- R5: After reset, `ser_dout_o` and `ser_dsync_o` stay low and no frame is sent until a word is loaded. Once a word is loaded, its sync appears within one serial clock period (2^(`div_sel_i`+1) cycles of `clk_i`).
- R6: A word is accepted when `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` then stays low until that word starts its frame.
- R7: When `ser_din_sync_i` is high at a falling serial edge, the next 16 falling edges carry one word. After the 16th bit, `rx_strobe_o` is high for one `clk_i` cycle if the word is addressed to this port, and `rx_word_o` holds the word during that cycle.
- R8: When `ser_din_sync_i` is high on the 16th bit of a word, that word still completes and a new word starts, so back-to-back input words are all delivered.
- R9: When `ser_din_sync_i` rises again before 16 bits have been taken, the partial word is discarded without a strobe, and counting restarts from the new sync.
- R10: Bits 13:11 of a received word carry the address. A word whose address equals `dev_id_i` is delivered on `rx_word_o`. Any other word gives no strobe and is sent unchanged on `ser_dout_o` in the next free output frame.
- R11: When a word waiting to be passed down the chain and a locally loaded word both wait for the same frame, the passed-down word goes first and the local word goes in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock, source of the serial clock |
| rst_ni | input | 1 | Active-low reset |
| div_sel_i | input | 2 | Serial clock divide select |
| dev_id_i | input | 3 | Strapped chain address of this port |
| tx_word_i | input | 16 | Word to transmit |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register free |
| rx_word_o | output | 16 | Last received word |
| rx_strobe_o | output | 1 | One-cycle pulse for a word addressed to this port |
| ser_clk_o | output | 1 | Serial bit clock |
| ser_dout_o | output | 1 | Serial data out |
| ser_dsync_o | output | 1 | Output frame sync |
| ser_din_i | input | 1 | Serial data in |
| ser_din_sync_i | input | 1 | Input frame sync |

## Verification
Two of this block's functions can compete for the same frame slot. One is a foreign word that finishes arriving and must be passed down the chain. The other is a local word that is waiting in the holding register. The test starts an input frame addressed elsewhere, then loads two local words so that both the foreign word and the second local word are waiting when the first local word reaches its last bit. It then checks that the output stream is first local word, foreign word, second local word, with the sync overlapping each last bit. A second coincidence, where a word completes on the same falling edge that a new input sync arrives, is checked by streaming two input words back to back and by forcing an early sync mid-word.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   localparam int unsigned FSP_WORD_W = 16;
   localparam int unsigned FSP_ID_W   = 3;
   localparam int unsigned FSP_ID_LSB = 11;
   localparam int unsigned FSP_SEL_W  = 2;
endpackage

// File: rtl/fsp_clkgen.sv
module fsp_clkgen #(
   parameter int unsigned SEL_W = fsp_pkg::FSP_SEL_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   output logic             sclk_o,
   output logic             rise_o,
   output logic             fall_o
);
   localparam int unsigned CNT_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("fsp_clkgen: SEL_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             sclk_q;
   logic             wrap;

   // half period minus one: 2^sel - 1
   always_comb lim = ~({CNT_W{1'b1}} << sel_i);
   always_comb wrap = (cnt_q >= lim);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign sclk_o = sclk_q;
   assign rise_o = wrap & ~sclk_q;
   assign fall_o = wrap & sclk_q;
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx #(
   parameter int unsigned W = fsp_pkg::FSP_WORD_W
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         rise_i,
   input  logic         next_valid_i,
   input  logic [W-1:0] next_word_i,
   output logic         take_o,
   output logic         dout_o,
   output logic         sync_o
);
   localparam int unsigned CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   if (W < 2) begin : g_bad_w
      $error("fsp_tx: W must be at least 2");
   end

   logic [W-1:0]     sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic             act_q, dout_q, sync_q;

   // a new word starts from idle, or overlaps the last bit of the current one
   assign take_o = rise_i & next_valid_i & (~act_q | (cnt_q == LAST));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
         dout_q <= 1'b0;
         sync_q <= 1'b0;
      end else if (rise_i) begin
         sync_q <= take_o;
         if (act_q) begin
            dout_q <= sh_q[W-1];
            sh_q   <= sh_q << 1;
            cnt_q  <= cnt_q + 1'b1;
         end else begin
            dout_q <= 1'b0;
         end
         if (take_o) begin
            sh_q  <= next_word_i;
            cnt_q <= '0;
            act_q <= 1'b1;
         end else if (act_q && cnt_q == LAST) begin
            act_q <= 1'b0;
         end
      end
   end

   assign dout_o = dout_q;
   assign sync_o = sync_q;
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx #(
   parameter int unsigned W = fsp_pkg::FSP_WORD_W
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         fall_i,
   input  logic         din_i,
   input  logic         sync_i,
   output logic         done_o,
   output logic [W-1:0] word_o
);
   localparam int unsigned CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   logic [W-2:0]     sh_q;
   logic [W-1:0]     word_q;
   logic [CNT_W-1:0] cnt_q;
   logic             act_q, done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         word_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (fall_i) begin
            if (act_q) begin
               sh_q  <= {sh_q[W-3:0], din_i};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) begin
                  word_q <= {sh_q, din_i};
                  done_q <= 1'b1;
                  act_q  <= 1'b0;
               end
            end
            // a sync restarts the count; mid-word this drops the partial word
            if (sync_i) begin
               act_q <= 1'b1;
               cnt_q <= '0;
            end
         end
      end
   end

   assign done_o = done_q;
   assign word_o = word_q;
endmodule

// File: rtl/fsp_port.sv
module fsp_port #(
   parameter int unsigned WORD_W     = fsp_pkg::FSP_WORD_W,
   parameter int unsigned ID_W       = fsp_pkg::FSP_ID_W,
   parameter int unsigned ID_LSB     = fsp_pkg::FSP_ID_LSB,
   parameter int unsigned SEL_W      = fsp_pkg::FSP_SEL_W,
   parameter bit          CASCADE_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SEL_W-1:0]  div_sel_i,
   input  logic [ID_W-1:0]   dev_id_i,
   input  logic [WORD_W-1:0] tx_word_i,
   input  logic              tx_valid_i,
   output logic              tx_ready_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              rx_strobe_o,
   output logic              ser_clk_o,
   output logic              ser_dout_o,
   output logic              ser_dsync_o,
   input  logic              ser_din_i,
   input  logic              ser_din_sync_i
);
   localparam int unsigned ID_MSB = ID_LSB + ID_W - 1;

   if (ID_MSB >= WORD_W) begin : g_bad_id
      $error("fsp_port: address field outside the word");
   end

   logic              rise, fall, take, rx_done, own;
   logic [WORD_W-1:0] rx_word;
   logic [WORD_W-1:0] hold_q, fwd_q, next_word;
   logic              hold_v, fwd_v, next_valid;

   fsp_clkgen #(.SEL_W(SEL_W)) u_clk (
      .clk_i (clk_i), .rst_ni(rst_ni), .sel_i(div_sel_i),
      .sclk_o(ser_clk_o), .rise_o(rise), .fall_o(fall)
   );

   fsp_tx #(.W(WORD_W)) u_tx (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
      .next_valid_i(next_valid), .next_word_i(next_word),
      .take_o(take), .dout_o(ser_dout_o), .sync_o(ser_dsync_o)
   );

   fsp_rx #(.W(WORD_W)) u_rx (
      .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall),
      .din_i(ser_din_i), .sync_i(ser_din_sync_i),
      .done_o(rx_done), .word_o(rx_word)
   );

   if (CASCADE_EN) begin : g_cascade
      assign own = (rx_word[ID_MSB:ID_LSB] == dev_id_i);
   end else begin : g_single
      assign own = 1'b1;
   end

   // passed-down words win the next slot over local words
   assign next_valid = fwd_v | hold_v;
   assign next_word  = fwd_v ? fwd_q : hold_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q <= '0;
         hold_v <= 1'b0;
         fwd_q  <= '0;
         fwd_v  <= 1'b0;
      end else begin
         if (tx_valid_i && !hold_v) begin
            hold_q <= tx_word_i;
            hold_v <= 1'b1;
         end else if (take && !fwd_v) begin
            hold_v <= 1'b0;
         end
         if (rx_done && !own) begin
            fwd_q <= rx_word;
            fwd_v <= 1'b1;
         end else if (take && fwd_v) begin
            fwd_v <= 1'b0;
         end
      end
   end

   assign tx_ready_o  = ~hold_v;
   assign rx_strobe_o = rx_done & own;
   assign rx_word_o   = rx_word;
endmodule

// File: rtl/fsp_port_sva.sv
module fsp_port_sva (
   input logic clk_i,
   input logic rst_ni,
   input logic tx_valid_i,
   input logic tx_ready_o,
   input logic rx_strobe_o,
   input logic ser_clk_o,
   input logic ser_dout_o,
   input logic ser_dsync_o
);
   a_r1_dout_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ser_dout_o) |-> $rose(ser_clk_o));

   a_r3_sync_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ser_dsync_o) |-> $rose(ser_clk_o));

   a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_strobe_o |=> !rx_strobe_o);

   a_r1_capture_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_strobe_o |-> $fell(ser_clk_o));

   a_r6_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
endmodule

bind fsp_port fsp_port_sva u_sva (
   .clk_i(clk_i), .rst_ni(rst_ni), .tx_valid_i(tx_valid_i),
   .tx_ready_o(tx_ready_o), .rx_strobe_o(rx_strobe_o),
   .ser_clk_o(ser_clk_o), .ser_dout_o(ser_dout_o), .ser_dsync_o(ser_dsync_o)
);

// File: tb/fsp_port_tb.sv
`timescale 1ns/1ps
module fsp_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  div_sel = 2'd1;
   logic [2:0]  dev_id = 3'd5;
   logic [15:0] tx_word = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready, rx_strobe, sclk, dout, dsync;
   logic [15:0] rx_word;
   logic        din = 1'b0, din_sync = 1'b0;

   int n_tests = 0, n_fail = 0;

   always #10 clk = ~clk;

   fsp_port u_dut (
      .clk_i(clk), .rst_ni(rst_n), .div_sel_i(div_sel), .dev_id_i(dev_id),
      .tx_word_i(tx_word), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
      .rx_word_o(rx_word), .rx_strobe_o(rx_strobe), .ser_clk_o(sclk),
      .ser_dout_o(dout), .ser_dsync_o(dsync), .ser_din_i(din),
      .ser_din_sync_i(din_sync)
   );

   // output frame monitor: samples on the falling serial edge
   logic [15:0] out_q [32];
   logic        out_ovl [32];
   int          out_n = 0, mon_cnt = 0, mon_err = 0;
   logic [15:0] mon_sh = '0;

   always @(negedge sclk) begin
      if (mon_cnt != 0) begin
         mon_sh = {mon_sh[14:0], dout};
         mon_cnt = mon_cnt - 1;
         if (mon_cnt == 0 && out_n < 32) begin
            out_q[out_n]   = mon_sh;
            out_ovl[out_n] = dsync;
            out_n = out_n + 1;
         end
      end
      if (dsync) begin
         if (mon_cnt != 0) mon_err = mon_err + 1;
         mon_cnt = 16;
      end
   end

   logic [15:0] rx_q [32];
   int          rx_n = 0;
   always @(negedge clk) begin
      if (rx_strobe && rx_n < 32) begin
         rx_q[rx_n] = rx_word;
         rx_n = rx_n + 1;
      end
   end

   function automatic logic [15:0] mk(input logic [2:0] addr, input logic [15:0] pay);
      return (pay & ~16'h3800) | (16'(addr) << 11);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] w);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_word = w;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic wait_out(input int k);
      while (out_n < k) @(negedge clk);
   endtask

   task automatic drv_sync();
      @(posedge sclk); #1;
      din_sync = 1'b1; din = 1'b0;
   endtask

   task automatic drv_bits(input logic [15:0] w, input int nb, input bit ovl);
      for (int i = 15; i > 15 - nb; i--) begin
         @(posedge sclk); #1;
         din = w[i];
         din_sync = (i == 0) && ovl;
      end
   endtask

   task automatic drv_idle();
      @(posedge sclk); #1;
      din_sync = 1'b0; din = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (40) @(negedge clk);
      chk("R5", "dout idle", dout, 0);
      chk("R5", "sync idle", dsync, 0);
      chk("R6", "ready after reset", tx_ready, 1);
      chk("R5", "no frame before load", out_n, 0);
   endtask

   task automatic t_div();
      for (int s = 0; s < 4; s++) begin
         int n;
         div_sel = 2'(s);
         repeat (3) @(posedge sclk);
         @(posedge sclk);
         n = 0;
         forever begin
            @(negedge clk);
            if (sclk) n++; else break;
         end
         chk("R2", "high phase length", n, 1 << s);
      end
      div_sel = 2'd1;
      repeat (3) @(posedge sclk);
   endtask

   task automatic t_single();
      int n, base;
      base = out_n;
      push(16'hA5C3);
      chk("R6", "ready low after accept", tx_ready, 0);
      n = 0;
      while (!dsync) begin @(negedge clk); n++; end
      chk("R5", "first sync within one period", n <= 4, 1);
      wait_out(base + 1);
      chk("R1", "single word msb first", out_q[base], 16'hA5C3);
      chk("R3", "no overlap on single", out_ovl[base], 0);
      repeat (8) @(negedge clk);
      chk("R5", "dout low after frame", dout, 0);
   endtask

   task automatic t_cont();
      int base;
      base = out_n;
      push(16'h1234);
      push(16'hFEDC);
      wait_out(base + 2);
      chk("R4", "first streamed word", out_q[base], 16'h1234);
      chk("R4", "sync overlaps last bit", out_ovl[base], 1);
      chk("R4", "second streamed word", out_q[base+1], 16'hFEDC);
   endtask

   task automatic t_own();
      int rb, ob;
      logic [15:0] w;
      rb = rx_n; ob = out_n;
      w = mk(3'd5, 16'h4ABC);
      drv_sync(); drv_bits(w, 16, 0); drv_idle();
      chk("R7", "one strobe for own word", rx_n, rb + 1);
      chk("R10", "own word delivered", rx_q[rb], w);
      repeat (40) @(negedge clk);
      chk("R10", "own word not passed on", out_n, ob);
   endtask

   task automatic t_foreign();
      int rb, ob;
      logic [15:0] w;
      rb = rx_n; ob = out_n;
      w = mk(3'd2, 16'h9157);
      drv_sync(); drv_bits(w, 16, 0); drv_idle();
      wait_out(ob + 1);
      chk("R10", "foreign word no strobe", rx_n, rb);
      chk("R10", "foreign word passed on", out_q[ob], w);
   endtask

   task automatic t_abort();
      int rb;
      logic [15:0] w;
      rb = rx_n;
      w = mk(3'd5, 16'h0F0F);
      drv_sync(); drv_bits(16'hFFFF, 5, 0);
      drv_sync(); drv_bits(w, 16, 0); drv_idle();
      chk("R9", "partial word dropped", rx_n, rb + 1);
      chk("R9", "word after restart", rx_q[rb], w);
   endtask

   task automatic t_rxcont();
      int rb;
      logic [15:0] a, b;
      rb = rx_n;
      a = mk(3'd5, 16'h8001);
      b = mk(3'd5, 16'h7FFE);
      drv_sync(); drv_bits(a, 16, 1); drv_bits(b, 16, 0); drv_idle();
      chk("R8", "both streamed words", rx_n, rb + 2);
      chk("R8", "first streamed input", rx_q[rb], a);
      chk("R8", "second streamed input", rx_q[rb+1], b);
   endtask

   task automatic t_prio();
      int ob;
      logic [15:0] f;
      ob = out_n;
      f = mk(3'd1, 16'h3C3C);
      fork
         begin drv_sync(); drv_bits(f, 16, 0); drv_idle(); end
         begin @(posedge sclk); @(posedge sclk); push(16'hBEEF); push(16'h0123); end
      join
      wait_out(ob + 3);
      chk("R11", "local word first", out_q[ob], 16'hBEEF);
      chk("R11", "passed word wins slot", out_q[ob+1], f);
      chk("R11", "local word after", out_q[ob+2], 16'h0123);
      chk("R4", "overlap into passed word", out_ovl[ob], 1);
      chk("R4", "overlap into local word", out_ovl[ob+1], 1);
   endtask

   initial begin
      fork
         begin
            repeat (5) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_div();
            t_single();
            t_cont();
            t_own();
            t_foreign();
            t_abort();
            t_rxcont();
            t_prio();
            repeat (40) @(negedge clk);
            chk("R3", "sync one period only", mon_err, 0);
         end
         begin
            repeat (100000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule